// File: doc/BRIEF.md
# Paging Address Codeword Builder and Matcher

This block holds a small table of paging address slots. Each slot is written through a parallel write port with an 18-bit address, a 2-bit function code that selects one of four sub-addresses, an enable flag and a frame number. During the write, the block turns the address and function code into a full 32-bit address codeword. The codeword carries a zero flag bit, the information field, ten BCH(31,21) check bits and an even-parity bit. Only that codeword, the enable and the frame number are stored.

A receiver presents each decoded 32-bit codeword with a strobe, together with the number of the frame it arrived in. The block compares the word against every slot at once. A slot can hit only when it is enabled, its frame number equals the current frame, and all 32 bits agree. One clock later the block reports a registered result: whether a slot hit, which slot, and the function code of that slot. This is the address recognition stage of a paging decoder. It follows an error-correction stage and a slot-loading interface, and neither of those belongs to this block.

Top module: `pg_addr_match`

## Requirements
- R1: After synchronous reset every slot is disabled, `res_valid` and `res_hit` are 0, and a probe made before any slot is written never hits.
- R2: A slot's codeword has bit 31 = 0, the address in bits 30..13 (MSB at bit 30), and the function code in bits 12..11.
- R3: Codeword bits 10..1 are the remainder of the 21 bits 31..11 multiplied by x^10, divided by x^10+x^9+x^8+x^6+x^5+x^3+1, with the remainder MSB at bit 10.
- R4: Codeword bit 0 makes the count of ones in bits 31..0 even.
- R5: A hit needs all 32 received bits to equal the slot's codeword. A word that differs in any single bit does not hit that slot.
- R6: A slot whose enable was written as 0 never hits, even if its codeword and frame match.
- R7: A slot hits only when `cur_frame` equals its stored frame number.
- R8: When several slots hit, `res_idx` reports the lowest slot index.
- R9: `res_valid` is high for exactly the one clock that follows a clock with `rx_valid` high. On a hit it carries `res_hit`=1, the slot index and the slot's function code.
- R10: When `res_valid` is high and no slot hits, `res_hit`, `res_idx` and `res_func` are all 0.
- R11: A write replaces all of a slot's fields. A probe strobed on a later clock sees only the new contents. A probe strobed on the same clock as a write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one slot |
| wr_idx | input | 3 | Slot to write |
| wr_addr | input | 18 | Address for the slot |
| wr_func | input | 2 | Function code (sub-address) for the slot |
| wr_on | input | 1 | Enable flag for the slot |
| wr_frame | input | 3 | Frame number for the slot |
| cur_frame | input | 3 | Frame in which the received word arrived |
| rx_valid | input | 1 | Received-word strobe |
| rx_word | input | 32 | Received codeword |
| res_valid | output | 1 | Result strobe, one clock after `rx_valid` |
| res_hit | output | 1 | A slot matched |
| res_idx | output | 3 | Index of the winning slot |
| res_func | output | 2 | Function code of the winning slot |

## Verification
The assertions check the following on every cycle:
- Every stored enabled codeword has a zero flag bit and even weight.
- A write lands in the addressed slot.
- At most one slot wins, and the winner is enabled and in the right frame.
- The result strobe follows the input strobe exactly.
- A miss reports zero index and zero function code.

Some behaviour only the bench scenarios can show. The check bits must agree with an independent polynomial division, which shows only when built words are sent back and hit. Every single-bit corruption must miss. The lowest index must win among duplicates. Reads issued right after rewrites must see the new contents.

// File: rtl/pg_cw_pkg.sv
package pg_cw_pkg;
  localparam int PG_SLOTS   = 8;
  localparam int PG_ADDR_W  = 18;
  localparam int PG_FUNC_W  = 2;
  localparam int PG_FRAME_W = 3;
  localparam int PG_CHK_W   = 10;
  // x^10+x^9+x^8+x^6+x^5+x^3+1
  localparam logic [PG_CHK_W:0] PG_POLY = 11'h769;
endpackage

// File: rtl/pg_cw_encode.sv
module pg_cw_encode #(
  parameter int ADDR_W = 18,
  parameter int FUNC_W = 2,
  parameter int CHK_W  = 10,
  parameter logic [CHK_W:0] POLY = 11'h769,
  localparam int INFO_W = 1 + ADDR_W + FUNC_W,
  localparam int CW_W   = INFO_W + CHK_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [FUNC_W-1:0] func,
  output logic [CW_W-1:0]   cw
);
  logic [INFO_W-1:0] info;
  logic [CHK_W-1:0]  rem;
  logic              fb;

  assign info = {1'b0, addr, func};

  // Bit-serial LFSR division, unrolled: info MSB first.
  always_comb begin
    rem = '0;
    fb  = 1'b0;
    for (int k = INFO_W - 1; k >= 0; k--) begin
      fb  = info[k] ^ rem[CHK_W-1];
      rem = {rem[CHK_W-2:0], 1'b0};
      if (fb) rem = rem ^ POLY[CHK_W-1:0];
    end
    cw = {info, rem, ^{info, rem}};
  end
endmodule

// File: rtl/pg_slot_store.sv
module pg_slot_store #(
  parameter int N_SLOTS = 8,
  parameter int CW_W    = 32,
  parameter int FRAME_W = 3,
  localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [CW_W-1:0]     wr_cw,
  input  logic                wr_on,
  input  logic [FRAME_W-1:0]  wr_frame,
  output logic [CW_W-1:0]     word_q  [N_SLOTS],
  output logic [FRAME_W-1:0]  frame_q [N_SLOTS],
  output logic [N_SLOTS-1:0]  en_q
);
  // Enables reset; codeword/frame storage is plain write-only array.
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (wr_en) en_q[wr_idx] <= wr_on;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      word_q[wr_idx]  <= wr_cw;
      frame_q[wr_idx] <= wr_frame;
    end
  end

  // R11: a write shows up in the addressed slot on the next cycle
  a_r11_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (word_q[$past(wr_idx)] == $past(wr_cw)) &&
              (frame_q[$past(wr_idx)] == $past(wr_frame)) &&
              (en_q[$past(wr_idx)] == $past(wr_on)));

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_form
    // R2 and R4: an enabled slot holds a flag-zero, even-weight word
    a_r2_r4_stored_form: assert property (@(posedge clk) disable iff (rst)
      en_q[i] |-> (!word_q[i][CW_W-1] && (^word_q[i] == 1'b0)));
  end
endmodule

// File: rtl/pg_matcher.sv
module pg_matcher #(
  parameter int N_SLOTS = 8,
  parameter int CW_W    = 32,
  parameter int FRAME_W = 3,
  parameter int FUNC_W  = 2,
  parameter int FUNC_LSB = 11,
  localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CW_W-1:0]     slot_word  [N_SLOTS],
  input  logic [FRAME_W-1:0]  slot_frame [N_SLOTS],
  input  logic [N_SLOTS-1:0]  slot_en,
  input  logic [FRAME_W-1:0]  cur_frame,
  input  logic                rx_valid,
  input  logic [CW_W-1:0]     rx_word,
  output logic                res_valid,
  output logic                res_hit,
  output logic [IDX_W-1:0]    res_idx,
  output logic [FUNC_W-1:0]   res_func
);
  logic [N_SLOTS-1:0] eq;
  logic [N_SLOTS-1:0] qual;
  logic [N_SLOTS-1:0] win_oh;
  logic [N_SLOTS:0]   seen;
  logic [IDX_W-1:0]   idx_n;
  logic               any_hit;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_cmp
    assign qual[i]    = slot_en[i] && (slot_frame[i] == cur_frame);
    assign eq[i]      = qual[i] && (slot_word[i] == rx_word);
    assign win_oh[i]  = eq[i] && !seen[i];
    assign seen[i+1]  = seen[i] | eq[i];
  end
  assign any_hit = seen[N_SLOTS];

  always_comb begin
    idx_n = '0;
    for (int i = 0; i < N_SLOTS; i++)
      if (win_oh[i]) idx_n = idx_n | IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_func  <= '0;
    end else begin
      res_valid <= rx_valid;
      res_hit   <= rx_valid && any_hit;
      res_idx   <= (rx_valid && any_hit) ? idx_n : '0;
      res_func  <= (rx_valid && any_hit) ? rx_word[FUNC_LSB +: FUNC_W] : '0;
    end
  end

  // R8: priority chain leaves at most one winner
  a_r8_single_winner: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $onehot0(win_oh));

  // R6/R7: a winner must be an enabled slot in the current frame
  a_r6_r7_qualified: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((win_oh & ~(slot_en & qual)) == '0));

  // R9: result strobe follows the input strobe by one clock
  a_r9_pulse_follows: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> res_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !res_valid);
endmodule

// File: rtl/pg_addr_match.sv
module pg_addr_match
  import pg_cw_pkg::*;
#(
  parameter int N_SLOTS = PG_SLOTS,
  parameter int ADDR_W  = PG_ADDR_W,
  parameter int FUNC_W  = PG_FUNC_W,
  parameter int FRAME_W = PG_FRAME_W,
  parameter int CHK_W   = PG_CHK_W,
  parameter logic [CHK_W:0] POLY = PG_POLY,
  localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CW_W   = 1 + ADDR_W + FUNC_W + CHK_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [FUNC_W-1:0]  wr_func,
  input  logic               wr_on,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [FRAME_W-1:0] cur_frame,
  input  logic               rx_valid,
  input  logic [CW_W-1:0]    rx_word,
  output logic               res_valid,
  output logic               res_hit,
  output logic [IDX_W-1:0]   res_idx,
  output logic [FUNC_W-1:0]  res_func
);
  logic [CW_W-1:0]    wr_cw;
  logic [CW_W-1:0]    word_q  [N_SLOTS];
  logic [FRAME_W-1:0] frame_q [N_SLOTS];
  logic [N_SLOTS-1:0] en_q;

  pg_cw_encode #(
    .ADDR_W(ADDR_W), .FUNC_W(FUNC_W), .CHK_W(CHK_W), .POLY(POLY)
  ) u_enc (
    .addr(wr_addr), .func(wr_func), .cw(wr_cw)
  );

  pg_slot_store #(
    .N_SLOTS(N_SLOTS), .CW_W(CW_W), .FRAME_W(FRAME_W)
  ) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_cw(wr_cw),
    .wr_on(wr_on), .wr_frame(wr_frame),
    .word_q(word_q), .frame_q(frame_q), .en_q(en_q)
  );

  pg_matcher #(
    .N_SLOTS(N_SLOTS), .CW_W(CW_W), .FRAME_W(FRAME_W),
    .FUNC_W(FUNC_W), .FUNC_LSB(CHK_W + 1)
  ) u_match (
    .clk(clk), .rst(rst),
    .slot_word(word_q), .slot_frame(frame_q), .slot_en(en_q),
    .cur_frame(cur_frame), .rx_valid(rx_valid), .rx_word(rx_word),
    .res_valid(res_valid), .res_hit(res_hit),
    .res_idx(res_idx), .res_func(res_func)
  );

  // R10: a miss reports zero index and function code
  a_r10_nohit_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_idx == '0 && res_func == '0));

  // R9: a hit is only ever reported alongside the result strobe
  a_r9_hit_in_window: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);
endmodule

// File: tb/sim_pg_addr_match.sv
`timescale 1ns/1ps
module sim_pg_addr_match;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [17:0] wr_addr = '0;
  logic [1:0]  wr_func = '0;
  logic        wr_on = 1'b0;
  logic [2:0]  wr_frame = '0;
  logic [2:0]  cur_frame = '0;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_word = '0;
  logic        res_valid, res_hit;
  logic [2:0]  res_idx;
  logic [1:0]  res_func;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [17:0] s_addr [8];
  logic [1:0]  s_func [8];
  logic        s_on   [8];
  logic [2:0]  s_frame[8];

  always #4 clk = ~clk;

  pg_addr_match u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr),
    .wr_func(wr_func), .wr_on(wr_on), .wr_frame(wr_frame), .cur_frame(cur_frame),
    .rx_valid(rx_valid), .rx_word(rx_word), .res_valid(res_valid),
    .res_hit(res_hit), .res_idx(res_idx), .res_func(res_func)
  );

  // Reference codeword by long division on the full 31-bit word (R2, R3, R4)
  function automatic logic [31:0] mk_cw(logic [17:0] a, logic [1:0] f);
    logic [30:0] v, d;
    v = {1'b0, a, f, 10'b0};
    d = v;
    for (int b = 30; b >= 10; b--)
      if (d[b]) d = d ^ (31'(11'h769) << (b - 10));
    v[9:0] = d[9:0];
    return {v, ^v};
  endfunction

  // Expected result: lowest enabled, in-frame, fully equal slot (R5-R8, R10)
  function automatic logic [5:0] model(logic [31:0] w, logic [2:0] fr);
    for (int i = 0; i < 8; i++)
      if (s_on[i] && s_frame[i] == fr && mk_cw(s_addr[i], s_func[i]) == w)
        return {1'b1, 3'(i), s_func[i]};
    return 6'b0;
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got hit/idx/func %b/%0d/%0d expected %b/%0d/%0d",
               req, act[5], act[4:2], act[1:0], exp[5], exp[4:2], exp[1:0]);
    end
  endtask

  task automatic wr(int idx, logic [17:0] a, logic [1:0] f, logic on, logic [2:0] fr);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_addr = a; wr_func = f; wr_on = on; wr_frame = fr;
    s_addr[idx] = a; s_func[idx] = f; s_on[idx] = on; s_frame[idx] = fr;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(string req, logic [31:0] w, logic [2:0] fr, logic [5:0] exp);
    @(negedge clk);
    rx_valid = 1'b1; rx_word = w; cur_frame = fr;
    @(negedge clk);
    rx_valid = 1'b0;
    if (res_valid !== 1'b1) begin
      n_chk++; n_bad++;
      $display("FAIL R9: res_valid got %b expected 1", res_valid);
    end
    check(req, {res_hit, res_idx, res_func}, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 8; i++) begin
      s_addr[i] = '0; s_func[i] = '0; s_on[i] = 1'b0; s_frame[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", {res_valid, res_hit, 4'b0}, 6'b0);
    probe("R1", 32'h0, 3'd0, 6'b0);
    probe("R1", mk_cw(18'h2a5c1, 2'd1), 3'd0, 6'b0);
    // R9: no strobe on an idle cycle
    @(negedge clk);
    check("R9", {res_valid, 5'b0}, 6'b0);

    // R2/R3/R4: all-zero info gives all-zero codeword
    n_chk++;
    if (mk_cw(18'h0, 2'd0) !== 32'h0) begin
      n_bad++;
      $display("FAIL R3: got %h expected 00000000", mk_cw(18'h0, 2'd0));
    end
    wr(0, 18'h0, 2'd0, 1'b1, 3'd0);
    probe("R2", 32'h0, 3'd0, {1'b1, 3'd0, 2'd0});

    // R2/R3/R4: built word hits in slot 3
    wr(3, 18'h2a5c1, 2'd2, 1'b1, 3'd5);
    w = mk_cw(18'h2a5c1, 2'd2);
    n_chk++;
    if (^w !== 1'b0 || w[31] !== 1'b0 || w[30:13] !== 18'h2a5c1) begin
      n_bad++;
      $display("FAIL R4: got %h expected even weight with flag 0", w);
    end
    probe("R3", w, 3'd5, {1'b1, 3'd3, 2'd2});

    // R5/R4: every single-bit corruption misses
    for (int b = 0; b < 32; b++)
      probe(b == 0 ? "R4" : "R5", w ^ (32'h1 << b), 3'd5, 6'b0);

    // R7: wrong frame
    probe("R7", w, 3'd4, 6'b0);
    // R6: disabled slot
    wr(3, 18'h2a5c1, 2'd2, 1'b0, 3'd5);
    probe("R6", w, 3'd5, 6'b0);

    // R8: duplicates, lowest index wins
    wr(6, 18'h01234, 2'd3, 1'b1, 3'd2);
    wr(2, 18'h01234, 2'd3, 1'b1, 3'd2);
    probe("R8", mk_cw(18'h01234, 2'd3), 3'd2, {1'b1, 3'd2, 2'd3});
    wr(2, 18'h01234, 2'd3, 1'b0, 3'd2);
    probe("R8", mk_cw(18'h01234, 2'd3), 3'd2, {1'b1, 3'd6, 2'd3});

    // R10: miss reports zeros
    probe("R10", 32'h7fffffff, 3'd2, 6'b0);

    // R11: rewrite replaces old contents
    wr(6, 18'h3ffff, 2'd1, 1'b1, 3'd7);
    probe("R11", mk_cw(18'h01234, 2'd3), 3'd2, 6'b0);
    probe("R11", mk_cw(18'h3ffff, 2'd1), 3'd7, {1'b1, 3'd6, 2'd1});
    // R11: probe in the same clock as a write sees old contents
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd6; wr_addr = 18'h00055; wr_func = 2'd0; wr_on = 1'b1; wr_frame = 3'd7;
    rx_valid = 1'b1; rx_word = mk_cw(18'h3ffff, 2'd1); cur_frame = 3'd7;
    @(negedge clk);
    wr_en = 1'b0; rx_valid = 1'b0;
    s_addr[6] = 18'h00055; s_func[6] = 2'd0;
    check("R11", {res_hit, res_idx, res_func}, {1'b1, 3'd6, 2'd1});
    probe("R11", mk_cw(18'h00055, 2'd0), 3'd7, {1'b1, 3'd6, 2'd0});

    // Random mix, small address pool to force duplicates
    for (int i = 0; i < 8; i++)
      wr(i, 18'($urandom % 4), 2'($urandom), ($urandom % 4) != 0, 3'($urandom % 2));
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 4;
      if (op == 0) begin
        wr(int'($urandom % 8), 18'($urandom % 4), 2'($urandom),
           ($urandom % 4) != 0, 3'($urandom % 2));
      end else begin
        int j;
        logic [2:0] fr;
        j = $urandom % 8;
        w = mk_cw(s_addr[j], s_func[j]);
        fr = (op == 3) ? 3'($urandom % 2) : s_frame[j];
        if (($urandom % 8) == 0) w = w ^ (32'h1 << ($urandom % 32));
        probe("R8", w, fr, model(w, fr));
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule